// File: doc/BRIEF.md
# Self-correcting decoded twisted-ring divide-by-eight counter

This block is a four-stage twisted-ring shift counter. On every enabled clock the stage contents move one place along the chain. The first stage takes the inverted value of the last stage, after that value passes through a correction gate. A cleared register therefore fills with ones one stage at a time and then empties again. The result is an eight-state cycle, so the block divides its clock by eight, while a plain recirculating ring of the same length would divide by only four.

Each of the eight states drives its own active-high decoded line. Every line is a two-input AND of stage bits or their complements, and this stays true at any chain length. A registered carry marks each wrap of the cycle.

A four-bit register can hold sixteen patterns, and eight of them lie outside the cycle. The correction term in the feedback steers each of these eight back into the cycle within a few clocks. A seed port can place any pattern in the register, either to start the count at a chosen phase or to exercise the recovery path. Reset stays the normal way to reach a known state.

Top module: `johnson_div8`

## Requirements
- R1: An active-low asynchronous reset clears every stage to 0 and holds carry_o low. The clear appears at the outputs without waiting for a clock edge.
- R2: On an enabled clock, stage i+1 takes the old value of stage i. Bit 0 of stage_o is the first stage and bit 3 is the last. The first stage takes ~s3 & (s0 | ~s2), where sK is the old bit K.
- R3: Starting from all zeros, stage_o written as bit0..bit3 steps through 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and then returns to 0000. The cycle repeats every eight enabled clocks.
- R4: When load_i is high at a clock edge, the register takes load_val_i whatever the value of en_i. No carry results from that edge.
- R5: When en_i is low and load_i is low, all stages keep their values and carry_o stays low.
- R6: dec_o[k] is high exactly when stage_o holds the k-th pattern of the R3 sequence, counting from k=0. The lines are built as follows: dec0 = ~s0&~s3, dec1 = s0&~s1, dec2 = s1&~s2, dec3 = s2&~s3, dec4 = s0&s3, dec5 = ~s0&s1, dec6 = ~s1&s2, dec7 = ~s2&s3. In every valid state exactly one line is high.
- R7: carry_o is high for exactly one cycle, the cycle after an enabled clock moves the register from 0001 to 0000. At all other times carry_o is low.
- R8: From any of the eight patterns outside the R3 sequence, the register reaches a valid pattern within five enabled clocks. Once it is in a valid pattern, enabled clocks never take it out of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Seed strobe, takes priority over en_i |
| load_val_i | input | 4 | Seed pattern, bit 0 is the first stage |
| stage_o | output | 4 | Raw stage bits, bit 0 is the first stage |
| dec_o | output | 8 | One-hot decoded state lines |
| carry_o | output | 1 | One-cycle pulse after each wrap to 0000 |

## Verification
The first input pattern is a long stretch of uninterrupted counting from reset. It separates the twisted-ring sequence and its decode from a plain recirculating ring, and it also shows the carry landing on the wrap alone. A second run gates the enable on and off in an irregular pattern, which separates holding from counting and shows that a stalled 0001 state raises no carry. All sixteen patterns are then seeded in turn, some with the enable high as well. This separates seed priority from counting and shows whether each unused pattern drains into the cycle within five clocks and stays there. A final reset dropped between clock edges tests whether the clear happens without waiting for an edge.

// File: rtl/jc_pkg.sv
package jc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } jc_op_e;

  // A legal twisted-ring pattern has at most one change along the chain.
  function automatic logic jc_is_valid(input logic [31:0] s, input int n);
    int edges;
    edges = 0;
    for (int i = 0; i < n - 1; i++) begin
      if (s[i] != s[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

endpackage

// File: rtl/jc_feedback.sv
module jc_feedback #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0] q_i,
  output logic              fb_o
);
  // Inverted tail, gated so that an isolated one followed by a zero cannot re-enter.
  assign fb_o = ~q_i[STAGES-1] & (q_i[0] | ~q_i[STAGES-2]);
endmodule

// File: rtl/jc_stage_reg.sv
module jc_stage_reg
  import jc_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  jc_op_e            op_i,
  input  logic              fb_i,
  input  logic [STAGES-1:0] load_val_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] q_next;

  always_comb begin
    unique case (op_i)
      OP_LOAD:  q_next = load_val_i;
      OP_SHIFT: q_next = {q_o[STAGES-2:0], fb_i};
      default:  q_next = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_next;
  end

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> (q_o[STAGES-1:1] == $past(q_o[STAGES-2:0])));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(q_o));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (q_o == $past(load_val_i)));
endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
  parameter int STAGES = 4,
  localparam int STATES = 2 * STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] q_i,
  output logic [STATES-1:0] dec_o
);
  for (genvar k = 0; k < STATES; k++) begin : g_line
    if (k == 0) begin : g_empty
      assign dec_o[k] = ~q_i[0] & ~q_i[STAGES-1];
    end else if (k < STAGES) begin : g_fill
      assign dec_o[k] = q_i[k-1] & ~q_i[k];
    end else if (k == STAGES) begin : g_full
      assign dec_o[k] = q_i[0] & q_i[STAGES-1];
    end else begin : g_drain
      assign dec_o[k] = ~q_i[k-STAGES-1] & q_i[k-STAGES];
    end
  end

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jc_pkg::jc_is_valid(32'(q_i), STAGES) |-> ($countones(dec_o) == 1));
endmodule

// File: rtl/jc_wrap.sv
module jc_wrap #(
  parameter int STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [STAGES-1:0] q_i,
  output logic              carry_o
);
  localparam logic [STAGES-1:0] LastState = {1'b1, {(STAGES-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) carry_o <= 1'b0;
    else         carry_o <= step_i && (q_i == LastState);
  end

  assert_carry_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (q_i == '0));

  assert_carry_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && q_i == LastState) |=> carry_o);
endmodule

// File: rtl/johnson_div8.sv
module johnson_div8
  import jc_pkg::*;
#(
  parameter int STAGES = 4,
  localparam int STATES = 2 * STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [STAGES-1:0] load_val_i,
  output logic [STAGES-1:0] stage_o,
  output logic [STATES-1:0] dec_o,
  output logic              carry_o
);
  jc_op_e op;
  logic   fb;
  logic   step;

  // Seed wins over count.
  always_comb begin
    if (load_i)    op = OP_LOAD;
    else if (en_i) op = OP_SHIFT;
    else           op = OP_HOLD;
  end
  assign step = (op == OP_SHIFT);

  jc_feedback #(.STAGES(STAGES)) u_fb (
    .q_i (stage_o),
    .fb_o(fb)
  );

  jc_stage_reg #(.STAGES(STAGES)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .fb_i      (fb),
    .load_val_i(load_val_i),
    .q_o       (stage_o)
  );

  jc_decode #(.STAGES(STAGES)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .q_i   (stage_o),
    .dec_o (dec_o)
  );

  jc_wrap #(.STAGES(STAGES)) u_wrap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .q_i    (stage_o),
    .carry_o(carry_o)
  );

  assert_closed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && jc_is_valid(32'(stage_o), STAGES)) |=> jc_is_valid(32'(stage_o), STAGES));
endmodule

// File: tb/johnson_div8_bench.sv
module johnson_div8_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [3:0] load_val_i = '0;
  logic [3:0] stage_o;
  logic [7:0] dec_o;
  logic       carry_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [3:0] m_state = '0;
  logic       m_carry = 1'b0;
  logic [3:0] seq [8] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111,
                          4'b1111, 4'b1110, 4'b1100, 4'b1000};
  // seq[k] is stored with bit0 = first stage (1000 written bit0..bit3 is 4'b0001)

  always #10 clk_i = ~clk_i;

  johnson_div8 u_johnson_div8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_i),
    .load_val_i(load_val_i), .stage_o(stage_o), .dec_o(dec_o), .carry_o(carry_o)
  );

  function automatic int idx_of(input logic [3:0] s);
    for (int k = 0; k < 8; k++) if (seq[k] == s) return k;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    int k;
    k = idx_of(m_state);
    check(stage_o == m_state, {req, " stage"}, stage_o, m_state);
    check(carry_o == m_carry, {req, " carry R7"}, carry_o, m_carry);
    if (k >= 0) check(dec_o == 8'(1 << k), {req, " decode R6"}, dec_o, 8'(1 << k));
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic tick(input string req);
    logic [3:0] nxt;
    logic       nc;
    int k;
    k = idx_of(m_state);
    nc = 1'b0;
    if (load_i) nxt = load_val_i;
    else if (en_i) begin
      if (k >= 0) begin
        nxt = seq[(k + 1) % 8];
        nc = (k == 7);
      end else begin
        nxt = {m_state[2:0], ~m_state[3] & (m_state[0] | ~m_state[2])};
      end
    end else nxt = m_state;
    @(posedge clk_i);
    m_state = nxt;
    m_carry = nc;
    @(negedge clk_i);
    compare(req);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int steps;
    bit seen_valid;
    bit gate;
    @(negedge clk_i);
    @(negedge clk_i);
    compare("R1 reset");
    check(dec_o == 8'h01, "R1 reset decode", dec_o, 1);
    rst_ni = 1'b1;

    // R3: free run, two full cycles plus
    en_i = 1'b1;
    for (int i = 0; i < 20; i++) tick("R3 run");
    en_i = 1'b0;
    while (m_state != 4'b1000) begin en_i = 1'b1; tick("R2 align"); end
    en_i = 1'b0;
    // R5: stall on 0001 (written bit0..bit3); no carry during hold
    for (int i = 0; i < 3; i++) tick("R5 hold");

    // R5: irregular enable
    gate = 1'b0;
    for (int i = 0; i < 40; i++) begin
      gate = ((i * 7) % 5) < 2;
      en_i = gate;
      tick("R5 gated");
    end

    // R4/R8: seed all sixteen patterns
    for (int p = 0; p < 16; p++) begin
      load_i = 1'b1;
      load_val_i = 4'(p);
      en_i = p[0];
      tick("R4 load");
      load_i = 1'b0;
      en_i = 1'b1;
      steps = 0;
      seen_valid = (idx_of(m_state) >= 0);
      for (int c = 0; c < 12; c++) begin
        tick("R2 recover");
        if (!seen_valid) steps++;
        if (idx_of(m_state) >= 0) seen_valid = 1'b1;
        else if (seen_valid) check(1'b0, "R8 left cycle", stage_o, 0);
      end
      check(seen_valid && steps <= 5, "R8 recovery clocks", steps, 5);
      en_i = 1'b0;
    end

    // R1: asynchronous clear between edges
    en_i = 1'b1;
    for (int i = 0; i < 3; i++) tick("R3 pre-reset");
    #3;
    rst_ni = 1'b0;
    #2;
    m_state = '0;
    m_carry = 1'b0;
    check(stage_o == 4'h0, "R1 async clear", stage_o, 0);
    check(carry_o == 1'b0, "R1 async carry", carry_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 9; i++) tick("R3 after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule